// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block turns a single oscillator clock into the timing skeleton of a small two-stage microcontroller pipeline. A 2-bit phase counter splits every instruction cycle into four equal phases, Q1 to Q4. It decodes the counter into four registered strobes that never overlap, and from those strobes it derives the per-phase actions of the core. These are the program counter advance, the instruction register load, the data read and the data write. It also produces a clock-out that runs at one quarter of the oscillator rate.

The block holds the instruction register and fills it with a new word at the end of each Q4. The core fetches the next word while it executes the current one. When the execute stage reports a taken branch, the word that was prefetched during that cycle is thrown away. An all-zero forced NOP takes its place in the following cycle, while the branch target is fetched. Decode, the ALU and the memories themselves are outside this block.

Top module: `quad_phase_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `q1`=1, `q2`=`q3`=`q4`=0, `clkout`=0, `nop_cycle`=0 and `exec_word`=0 (the NOP encoding).
- R2: Exactly one of `q1..q4` is high in every oscillator cycle, and they advance Q1, Q2, Q3, Q4, then back to Q1.
- R3: `pc_inc` is high exactly in the Q1 phase.
- R4: `ir_load` is high exactly in Q4. At the clock edge that ends Q4, `exec_word` takes the value of `prog_word`, unless a flush is taken (R7). `exec_word` does not change at any other edge.
- R5: `rd_stb` is high only in Q2 and `wr_stb` only in Q4. Both are high only in a cycle that executes a real instruction.
- R6: The first instruction cycle after reset only fetches. `rd_stb` and `wr_stb` stay low through it.
- R7: If `branch_taken` is high at the edge that ends Q4 of a cycle that executes a real instruction, then the next cycle is a forced NOP. In that cycle `exec_word`=0, `nop_cycle` is high for all four phases, and there are no data strobes.
- R8: `branch_taken` has no effect when it is high in the fetch-only cycle after reset or in a forced-NOP cycle. In those cases the next cycle executes the fetched word.
- R9: `clkout` is low in Q1 and Q2 and high in Q3 and Q4, so its period is four oscillator clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| branch_taken | input | 1 | Execute stage changes the program counter this cycle |
| prog_word | input | IW | Word read from program memory |
| q1 | output | 1 | Phase 1 strobe |
| q2 | output | 1 | Phase 2 strobe |
| q3 | output | 1 | Phase 3 strobe |
| q4 | output | 1 | Phase 4 strobe |
| pc_inc | output | 1 | Program counter advance enable |
| ir_load | output | 1 | Instruction register load slot |
| rd_stb | output | 1 | Data operand read strobe |
| wr_stb | output | 1 | Data destination write strobe |
| nop_cycle | output | 1 | Current cycle is a flushed, forced NOP |
| clkout | output | 1 | Quarter-rate clock-out |
| exec_word | output | IW | Instruction register contents being executed |

## Verification
The bench goes after back-to-back branches. If a design let a forced NOP take a branch, a whole run of cycles would be flushed and real instructions would be lost. It also raises branch requests in the fetch-only cycle after reset. A design that honoured such a request would discard the very first instruction, and a design that did not block data strobes in that cycle would write memory with an undefined word. Mid-run resets check that the phase and the clock-out return to Q1 and low. A design that latches the word one phase too early or too late would show a wrong `exec_word` in Q1.

// File: rtl/quad_phase_seq.sv
module quad_phase_seq #(
  parameter int IW = 14,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          branch_taken,
  input  logic [IW-1:0] prog_word,
  output logic          q1,
  output logic          q2,
  output logic          q3,
  output logic          q4,
  output logic          pc_inc,
  output logic          ir_load,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic          nop_cycle,
  output logic          clkout,
  output logic [IW-1:0] exec_word
);
  localparam int NPH = 4;
  localparam int CW  = $clog2(NPH);

  logic [CW-1:0]  cnt, cnt_nx;
  logic [NPH-1:0] ph;
  logic           live, take, exec_real;

  assign cnt_nx    = cnt + 1'b1;
  assign exec_real = live & ~nop_cycle;
  assign take      = branch_taken & exec_real;

  assign q1 = ph[0];
  assign q2 = ph[1];
  assign q3 = ph[2];
  assign q4 = ph[3];

  assign pc_inc  = q1;
  assign ir_load = q4;
  assign rd_stb  = q2 & exec_real;
  assign wr_stb  = q4 & exec_real;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      ph        <= NPH'(1);
      clkout    <= 1'b0;
      live      <= 1'b0;
      nop_cycle <= 1'b0;
      exec_word <= NOP_WORD;
    end else begin
      cnt    <= cnt_nx;
      ph     <= NPH'(1) << cnt_nx;
      clkout <= cnt_nx[CW-1];
      if (ph[NPH-1]) begin
        live      <= 1'b1;
        nop_cycle <= take;
        exec_word <= take ? NOP_WORD : prog_word;
      end
    end
  end
endmodule

module quad_phase_seq_chk #(parameter int IW = 14) (
  input logic          clk,
  input logic          rst,
  input logic          q1,
  input logic          q2,
  input logic          q3,
  input logic          q4,
  input logic          pc_inc,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic          nop_cycle,
  input logic          clkout,
  input logic [IW-1:0] exec_word
);
  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones({q1, q2, q3, q4}) == 1);
  assert_order_R2: assert property (@(posedge clk) disable iff (rst)
    q1 |=> q2);
  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    q4 |=> q1);
  assert_pc_slot_R3: assert property (@(posedge clk) disable iff (rst)
    q4 |=> pc_inc);
  assert_ir_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !q4 |=> $stable(exec_word));
  assert_rd_slot_R5: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> (q2 && !nop_cycle));
  assert_wr_slot_R5: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (q4 && !nop_cycle));
  assert_nop_word_R7: assert property (@(posedge clk) disable iff (rst)
    nop_cycle |-> (exec_word == '0));
  assert_no_chain_R8: assert property (@(posedge clk) disable iff (rst)
    (nop_cycle && q4) |=> !nop_cycle);
  assert_clk_low_R9: assert property (@(posedge clk) disable iff (rst)
    (q1 || q2) |-> !clkout);
  assert_clk_high_R9: assert property (@(posedge clk) disable iff (rst)
    (q3 || q4) |-> clkout);
endmodule

bind quad_phase_seq quad_phase_seq_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst(rst), .q1(q1), .q2(q2), .q3(q3), .q4(q4),
  .pc_inc(pc_inc), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .nop_cycle(nop_cycle), .clkout(clkout), .exec_word(exec_word)
);

// File: tb/quad_phase_seq_bench.sv
module quad_phase_seq_bench;
  localparam int IW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic branch_taken = 1'b0;
  logic [IW-1:0] prog_word = '0;
  logic q1, q2, q3, q4, pc_inc, ir_load, rd_stb, wr_stb, nop_cycle, clkout;
  logic [IW-1:0] exec_word;

  int n_run = 0, n_fail = 0;
  int m_ph;
  bit m_valid, m_nop;
  logic [IW-1:0] m_word;

  always #10 clk = ~clk;

  quad_phase_seq #(.IW(IW)) u_quad_phase_seq (
    .clk(clk), .rst(rst), .branch_taken(branch_taken), .prog_word(prog_word),
    .q1(q1), .q2(q2), .q3(q3), .q4(q4), .pc_inc(pc_inc), .ir_load(ir_load),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .nop_cycle(nop_cycle), .clkout(clkout),
    .exec_word(exec_word)
  );

  function automatic logic [3:0] exp_ph(int p);
    return 4'(1) << p;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit ex;
    ex = m_valid && !m_nop;
    chk("R2 phases", {28'd0, q4, q3, q2, q1}, {28'd0, exp_ph(m_ph)});
    chk("R3 pc_inc", {31'd0, pc_inc}, {31'd0, m_ph == 0});
    chk("R4 ir_load", {31'd0, ir_load}, {31'd0, m_ph == 3});
    chk("R4 exec_word", {18'd0, exec_word}, {18'd0, m_word});
    chk("R5 R6 rd_stb", {31'd0, rd_stb}, {31'd0, ex && m_ph == 1});
    chk("R5 R6 wr_stb", {31'd0, wr_stb}, {31'd0, ex && m_ph == 3});
    chk("R7 R8 nop_cycle", {31'd0, nop_cycle}, {31'd0, m_nop});
    chk("R9 clkout", {31'd0, clkout}, {31'd0, m_ph >= 2});
  endtask

  task automatic model_reset();
    m_ph = 0; m_valid = 0; m_nop = 0; m_word = '0;
  endtask

  task automatic do_reset(int n);
    rst = 1'b1;
    repeat (n) @(posedge clk);
    model_reset();
    @(negedge clk);
    chk("R1 reset q1", {31'd0, q1}, 32'd1);
    chk("R1 reset clkout", {31'd0, clkout}, 32'd0);
    chk("R1 reset nop", {31'd0, nop_cycle}, 32'd0);
    chk("R1 reset word", {18'd0, exec_word}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic step(bit br, logic [IW-1:0] pw);
    bit take;
    branch_taken = br;
    prog_word = pw;
    @(posedge clk);
    if (m_ph == 3) begin
      take = br && m_valid && !m_nop;
      m_word = take ? '0 : pw;
      m_nop = take;
      m_valid = 1;
    end
    m_ph = (m_ph + 1) % 4;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset(3);
    check_all();
    // R6 R8: branch held high through the fetch-only cycle
    for (int i = 0; i < 4; i++) step(1'b1, 14'h2aaa);
    // R7 R8: branch in every slot, flush then ignored
    for (int i = 0; i < 16; i++) step(1'b1, 14'(i + 1));
    for (int i = 0; i < 8; i++) step(1'b0, 14'h3fff);
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 1200; i++)
        step(($urandom % 3) == 0, IW'($urandom));
      @(negedge clk);
      do_reset(1 + r);
      check_all();
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    n_run++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule